// File: doc/BRIEF.md
# Programmable Gated Display Clock Divider

This block generates the pixel-rate clocks for a display timing channel from one of four source clocks. All four sources are modelled as single-cycle tick enables derived from one reference clock. Each tick marks one edge of its source, so a source clock has a period of two ticks. One 32-bit control register selects the source and sets a 4-bit divide factor. A separate bit halves the rate on the secondary output. Each of the two outputs has its own gate bit. The outputs are 50%-duty levels in the reference clock domain.

The first stage counts ticks of the selected source. Its level toggles after (factor + 1) ticks, so the primary output has a period of 2·(factor + 1) source ticks. A small state machine follows the first stage. It either repeats every first-stage toggle, or, in halving mode, toggles on every second one to drive the secondary output.

Software writes the register through a bit-masked write port, so a field can be changed without a read-modify-write sequence. Two command strobes turn both gates on or both off at once. The register is always readable on `rd_data`.

The secondary state machine has these states:
- `B_OFF`: gate clear, output low.
- `B_LOW_1`: low, first phase.
- `B_LOW_2`: low, second phase, used only when halving.
- `B_HIGH_1`: high, first phase.
- `B_HIGH_2`: high, second phase, used only when halving.

Its transitions are:
- Gate set in `B_OFF` → `B_LOW_1`.
- Terminal count in `B_LOW_1` → `B_HIGH_1`, or → `B_LOW_2` when halving.
- Terminal count in `B_LOW_2` → `B_HIGH_1`.
- Terminal count in `B_HIGH_1` → `B_LOW_1`, or → `B_HIGH_2` when halving.
- Terminal count in `B_HIGH_2` → `B_LOW_1`.
- Gate clear from any state → `B_OFF`.

Top module: `disp_clkgen`

## Requirements
- R1: After reset the register reads 0x00000000, both clock outputs are low and `en_status` is low.
- R2: The register fields are at fixed bit positions:
  - bit 31: primary gate.
  - bits 25:24: source select.
  - bit 15: secondary gate.
  - bit 11: halve enable.
  - bits 3:0: divide factor.

  Every other bit reads 0 and ignores writes, so the defined-bit mask is 0x8300880F.
- R3: On a write, only the bits set in `wr_mask` take the value of `wr_data`. All other bits keep their value.
- R4: `cmd_enable` sets both gate bits and `cmd_disable` clears both. Both commands override a same-cycle write on the gate bits, and `cmd_disable` wins over `cmd_enable`.
- R5: `en_status` is high whenever either gate bit is set.
- R6: With the divide factor D, the primary level toggles every D+1 ticks of the selected source. With source s ticking every s+1 reference cycles, each half-period is (D+1)·(s+1) cycles.
- R7: The secondary output has the same half-period as the primary when halve enable is 0, and twice that half-period when it is 1. It keeps a 50% duty in both cases.
- R8: Source select value s routes `src_tick[s]` to the divider.
- R9: An output whose gate bit is clear stays low. When both gate bits are clear, the divider and the state machine go back to their initial state within one cycle.
- R10: A new divide factor is loaded only at the divider's terminal count, so the half-period already in progress completes with the old factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | One tick enable per source clock |
| wr_en | input | 1 | Register write strobe |
| wr_mask | input | 32 | Per-bit write mask |
| wr_data | input | 32 | Write data |
| cmd_enable | input | 1 | Sets both gate bits |
| cmd_disable | input | 1 | Clears both gate bits |
| rd_data | output | 32 | Register readback |
| en_status | output | 1 | Either gate set |
| clk_pri | output | 1 | Gated primary divided clock |
| clk_sec | output | 1 | Gated, optionally halved secondary clock |

## Verification
A corrupted register bit shows up on `rd_data` in the cycle after the write that caused it. A wrong terminal-count compare or a wrong divider reload shows up as a half-period of the wrong length on `clk_pri`, one half-period after the bad compare. A state machine that skips or repeats a phase shows up as an unequal high and low time on `clk_sec` within two primary half-periods. A gate that leaks shows up as a toggle on a supposedly silent output within one divided period.

// File: rtl/disp_clkgen_pkg.sv
package disp_clkgen_pkg;
    localparam int REG_W        = 32;
    localparam int GATE_PRI_BIT = 31;
    localparam int GATE_SEC_BIT = 15;
    localparam int HALF_BIT     = 11;
    localparam int SEL_LSB      = 24;
    localparam int DIV_LSB      = 0;

    typedef enum logic [2:0] {
        B_OFF    = 3'd0,
        B_LOW_1  = 3'd1,
        B_LOW_2  = 3'd2,
        B_HIGH_1 = 3'd3,
        B_HIGH_2 = 3'd4
    } half_state_t;

    function automatic logic [REG_W-1:0] defined_mask(input int sel_w, input int div_w);
        logic [REG_W-1:0] m;
        m = '0;
        m[GATE_PRI_BIT] = 1'b1;
        m[GATE_SEC_BIT] = 1'b1;
        m[HALF_BIT]     = 1'b1;
        for (int i = 0; i < sel_w; i++) m[SEL_LSB + i] = 1'b1;
        for (int i = 0; i < div_w; i++) m[DIV_LSB + i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/disp_clkgen_regs.sv
module disp_clkgen_regs
    import disp_clkgen_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_mask,
    input  logic [REG_W-1:0] wr_data,
    input  logic             cmd_enable,
    input  logic             cmd_disable,
    output logic [REG_W-1:0] ctrl_q
);
    localparam logic [REG_W-1:0] KEEP = defined_mask(SEL_W, DIV_W);

    logic [REG_W-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) ctrl_d = (ctrl_q & ~wr_mask) | (wr_data & wr_mask);
        if (cmd_enable) begin
            ctrl_d[GATE_PRI_BIT] = 1'b1;
            ctrl_d[GATE_SEC_BIT] = 1'b1;
        end
        if (cmd_disable) begin
            ctrl_d[GATE_PRI_BIT] = 1'b0;
            ctrl_d[GATE_SEC_BIT] = 1'b0;
        end
        ctrl_d = ctrl_d & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/disp_clkgen_div.sv
module disp_clkgen_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             lvl,
    output logic             tc
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_act;

    assign tc = run & tick & (cnt == div_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_act <= '0;
            lvl     <= 1'b0;
        end else if (!run) begin
            cnt     <= '0;
            div_act <= div_cfg;
            lvl     <= 1'b0;
        end else if (tc) begin
            cnt     <= '0;
            div_act <= div_cfg;
            lvl     <= ~lvl;
        end else if (tick) begin
            cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/disp_clkgen_half_fsm.sv
module disp_clkgen_half_fsm
    import disp_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic halve,
    input  logic tc,
    output logic lvl
);
    half_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        if (!gate) begin
            state_nxt = B_OFF;
        end else begin
            unique case (state)
                B_OFF:    state_nxt = B_LOW_1;
                B_LOW_1:  if (tc) state_nxt = halve ? B_LOW_2 : B_HIGH_1;
                B_LOW_2:  if (tc) state_nxt = B_HIGH_1;
                B_HIGH_1: if (tc) state_nxt = halve ? B_HIGH_2 : B_LOW_1;
                B_HIGH_2: if (tc) state_nxt = B_LOW_1;
                default:  state_nxt = B_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= B_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            B_HIGH_1, B_HIGH_2: lvl = 1'b1;
            default:            lvl = 1'b0;
        endcase
    end
endmodule

// File: rtl/disp_clkgen.sv
module disp_clkgen
    import disp_clkgen_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_mask,
    input  logic [REG_W-1:0] wr_data,
    input  logic             cmd_enable,
    input  logic             cmd_disable,
    output logic [REG_W-1:0] rd_data,
    output logic             en_status,
    output logic             clk_pri,
    output logic             clk_sec
);
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [REG_W-1:0] ctrl;
    logic             gate_pri, gate_sec, halve, tick, a_lvl, a_tc, b_lvl;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div_cfg;

    disp_clkgen_regs #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_data(wr_data), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .ctrl_q(ctrl)
    );

    assign gate_pri = ctrl[GATE_PRI_BIT];
    assign gate_sec = ctrl[GATE_SEC_BIT];
    assign halve    = ctrl[HALF_BIT];
    assign sel      = ctrl[SEL_LSB +: SEL_W];
    assign div_cfg  = ctrl[DIV_LSB +: DIV_W];

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (sel == SEL_W'(i)) tick = src_tick[i];
    end

    disp_clkgen_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(gate_pri | gate_sec), .tick(tick),
        .div_cfg(div_cfg), .lvl(a_lvl), .tc(a_tc)
    );

    disp_clkgen_half_fsm u_half (
        .clk(clk), .rst_n(rst_n), .gate(gate_sec), .halve(halve),
        .tc(a_tc), .lvl(b_lvl)
    );

    assign rd_data   = ctrl;
    assign en_status = gate_pri | gate_sec;
    assign clk_pri   = a_lvl & gate_pri;
    assign clk_sec   = b_lvl;
endmodule

// File: rtl/disp_clkgen_chk.sv
module disp_clkgen_chk
    import disp_clkgen_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_mask,
    input logic [REG_W-1:0] wr_data,
    input logic             cmd_enable,
    input logic             cmd_disable,
    input logic [REG_W-1:0] rd_data,
    input logic             clk_pri,
    input logic             clk_sec
);
    localparam logic [REG_W-1:0] KEEP = defined_mask(2, 4);

    p_undef_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~KEEP) == '0);

    p_masked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cmd_enable && !cmd_disable) |=>
        rd_data == ((($past(rd_data) & ~$past(wr_mask)) | ($past(wr_data) & $past(wr_mask))) & KEEP));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cmd_enable && !cmd_disable) |=> $stable(rd_data));

    p_enable_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_enable && !cmd_disable) |=> (rd_data[GATE_PRI_BIT] && rd_data[GATE_SEC_BIT]));

    p_disable_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disable |=> (!rd_data[GATE_PRI_BIT] && !rd_data[GATE_SEC_BIT]));

    p_both_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[GATE_PRI_BIT] && !rd_data[GATE_SEC_BIT]) |=> (!clk_pri && !clk_sec));
endmodule

bind disp_clkgen disp_clkgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .rd_data(rd_data),
    .clk_pri(clk_pri), .clk_sec(clk_sec)
);

// File: tb/disp_clkgen_test.sv
module disp_clkgen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick;
    logic        wr_en = 1'b0;
    logic [31:0] wr_mask = '0;
    logic [31:0] wr_data = '0;
    logic        cmd_enable = 1'b0;
    logic        cmd_disable = 1'b0;
    logic [31:0] rd_data;
    logic        en_status, clk_pri, clk_sec;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [3:0] refcnt = '0;

    typedef struct { int sig; int len; string tag; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    always_ff @(posedge clk) refcnt <= (refcnt == 4'd11) ? 4'd0 : refcnt + 4'd1;
    always_comb
        for (int k = 0; k < 4; k++) src_tick[k] = ((refcnt % (k + 1)) == 0);

    disp_clkgen uut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
        .wr_mask(wr_mask), .wr_data(wr_data), .cmd_enable(cmd_enable),
        .cmd_disable(cmd_disable), .rd_data(rd_data), .en_status(en_status),
        .clk_pri(clk_pri), .clk_sec(clk_sec)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic logic pick(input int s);
        return (s == 0) ? clk_pri : clk_sec;
    endfunction

    task automatic write(input logic [31:0] m, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_mask = m; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_mask = '0; wr_data = '0;
    endtask

    task automatic wait_toggle(input int s);
        logic prev;
        prev = pick(s);
        do @(negedge clk); while (pick(s) == prev);
    endtask

    // monitor: pops expected half-periods and measures them
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            begin
                exp_t it;
                int n;
                logic prev;
                it = exp_q[0];
                wait_toggle(it.sig);
                wait_toggle(it.sig);
                prev = pick(it.sig);
                n = 0;
                do begin @(negedge clk); n++; end while (pick(it.sig) == prev);
                check(n == it.len, it.tag, n, it.len);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic expect_half(input int s, input int len, input string tag);
        exp_t it;
        it.sig = s; it.len = len; it.tag = tag;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int toggles;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 32'h0, "R1 reg", rd_data, 0);
        check(!clk_pri && !clk_sec && !en_status, "R1 outputs", {clk_pri, clk_sec, en_status}, 0);

        // R2 undefined bits
        write(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check(rd_data == 32'h8300_880F, "R2 defined mask", rd_data, 32'h8300_880F);
        write(32'hFFFF_FFFF, 32'h0);
        check(rd_data == 32'h0, "R2 clear", rd_data, 0);

        // R3 masked write
        write(32'hFFFF_FFFF, 32'h0000_0805);
        write(32'h0300_0000, 32'hFFFF_FFFF);
        check(rd_data == 32'h0300_0805, "R3 sel only", rd_data, 32'h0300_0805);
        write(32'h0000_000F, 32'h0000_0002);
        check(rd_data == 32'h0300_0802, "R3 div only", rd_data, 32'h0300_0802);

        // R4 / R5 commands
        @(negedge clk); cmd_enable = 1'b1;
        @(negedge clk); cmd_enable = 1'b0;
        check(rd_data == 32'h8300_8802, "R4 enable", rd_data, 32'h8300_8802);
        check(en_status, "R5 status on", en_status, 1);
        @(negedge clk); cmd_enable = 1'b1; cmd_disable = 1'b1;
        @(negedge clk); cmd_enable = 1'b0; cmd_disable = 1'b0;
        check(rd_data == 32'h0300_0802, "R4 disable wins", rd_data, 32'h0300_0802);
        check(!en_status, "R5 status off", en_status, 0);
        @(negedge clk); cmd_disable = 1'b1; wr_en = 1'b1; wr_mask = 32'h8000_8000; wr_data = 32'h8000_8000;
        @(negedge clk); cmd_disable = 1'b0; wr_en = 1'b0; wr_mask = '0; wr_data = '0;
        check(rd_data[31] == 1'b0 && rd_data[15] == 1'b0, "R4 override write", rd_data, 32'h0300_0802);
        write(32'h0000_8000, 32'h0000_8000);
        check(en_status, "R5 single gate", en_status, 1);

        // R6 / R7 / R8 rates
        write(32'hFFFF_FFFF, 32'h8000_8000);
        expect_half(0, 1, "R6 src0 div0 pri");
        expect_half(1, 1, "R7 src0 div0 sec");
        write(32'h0000_000F, 32'h3);
        expect_half(0, 4, "R6 src0 div3 pri");
        write(32'h0000_0800, 32'h800);
        expect_half(1, 8, "R7 halved sec");
        expect_half(0, 4, "R7 pri unaffected by halve");
        write(32'h0300_000F, 32'h0200_0001);
        expect_half(0, 6, "R8 src2 div1 pri");
        expect_half(1, 12, "R8 src2 halved sec");
        write(32'h0300_0800, 32'h0300_0000);
        expect_half(1, 8, "R8 src3 div1 sec");

        // R9 gating
        @(negedge clk); cmd_disable = 1'b1;
        @(negedge clk); cmd_disable = 1'b0;
        toggles = 0;
        repeat (40) begin @(negedge clk); if (clk_pri || clk_sec) toggles++; end
        check(toggles == 0, "R9 both off low", toggles, 0);
        write(32'hFFFF_FFFF, 32'h0000_8000);
        toggles = 0;
        repeat (40) begin @(negedge clk); if (clk_pri) toggles++; end
        check(toggles == 0, "R9 pri gated", toggles, 0);
        expect_half(1, 1, "R9 sec runs alone");

        // R10 divider reload at terminal count
        write(32'hFFFF_FFFF, 32'h8000_0007);
        wait_toggle(0);
        wait_toggle(0);
        begin
            int n;
            logic prev;
            prev = clk_pri;
            n = 0;
            do begin
                @(negedge clk); n++;
                if (n == 2) begin wr_en = 1'b1; wr_mask = 32'hF; wr_data = 32'h1; end
                else begin wr_en = 1'b0; wr_mask = '0; wr_data = '0; end
            end while (clk_pri == prev);
            check(n == 8, "R10 old period completes", n, 8);
            prev = clk_pri;
            n = 0;
            do begin @(negedge clk); n++; end while (clk_pri == prev);
            check(n == 2, "R10 new period", n, 2);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule